// File: doc/BRIEF.md
# Four-Mode Significand Rounding Unit

This block reduces a sign-magnitude significand to a narrower kept width. The input holds the kept bits and, below them, several extra low-order bits that the kept width cannot hold. A 2-bit mode input picks one of four rounding rules. Two of the rules depend on the sign of the value.

The outputs are the rounded kept significand, a carry flag and an inexact flag. The carry flag tells the exponent logic downstream to add one. The inexact flag shows that any dropped information was lost. The rounding decision itself is combinational. A parameter places an output register after it, or leaves the path purely combinational. The block does not adjust the exponent beyond the carry flag, does not normalise, and does not treat special values.

Top module: `round4_unit`

## Requirements
- R1: With mode 2'b00 (nearest), the kept part is incremented when the dropped part is greater than half of one kept LSB. It is left unchanged when the dropped part is less than half.
- R2: With mode 2'b00, a dropped part exactly equal to half (the top dropped bit is 1 and all lower dropped bits are 0) rounds to the even result. The kept part is incremented only if its LSB is 1.
- R3: With mode 2'b01 (toward negative infinity), a negative inexact value has its magnitude incremented. A positive value is truncated.
- R4: With mode 2'b10 (toward positive infinity), a positive inexact value has its magnitude incremented. A negative value is truncated.
- R5: With mode 2'b11 (toward zero), the kept part is output unchanged and carry_out is 0, for either sign.
- R6: inexact is 1 exactly when any dropped bit is 1, in every mode.
- R7: When an increment overflows an all-ones kept part, carry_out is 1 and sig_out is a single 1 in its MSB followed by zeros.
- R8: When all dropped bits are 0, sig_out equals the kept part and carry_out is 0, in every mode and for either sign.
- R9: With REG_OUT=1, the outputs reflect the inputs applied before the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| sig_in | input | IN_W | Magnitude: kept bits in the upper KEEP_W positions, dropped bits below them |
| mode | input | 2 | Rounding rule: 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| sig_out | output | KEEP_W | Rounded kept magnitude |
| carry_out | output | 1 | Rounding overflowed the kept width |
| inexact | output | 1 | At least one dropped bit was non-zero |

## Verification
The assertions take for granted that at least two bits are dropped and at least two are kept. They also assume that the inputs hold steady around the sampling edge, so a registered output can be related to the inputs of the cycle before. The assertions treat every sign, magnitude and mode combination as legal, so the stimulus imposes no constraint on sign, magnitude or mode. Random magnitudes cover the interior of the input space. Directed cases force the exact-half pattern with both kept-LSB parities, an all-ones kept part under each mode, and exact inputs, because random draws rarely reach these.

// File: rtl/round4_unit.sv
module round4_unit #(
  parameter int IN_W    = 12,
  parameter int KEEP_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sign_in,
  input  logic [IN_W-1:0]   sig_in,
  input  logic [1:0]        mode,
  output logic [KEEP_W-1:0] sig_out,
  output logic              carry_out,
  output logic              inexact
);
  localparam int DROP_W = IN_W - KEEP_W;
  localparam logic [KEEP_W-1:0] MSB_ONLY = {1'b1, {(KEEP_W-1){1'b0}}};

  logic [KEEP_W-1:0] kept;
  logic              guard, sticky, bump;
  logic [KEEP_W:0]   sum;
  logic [KEEP_W-1:0] res_c;
  logic              inex_c;

  assign kept   = sig_in[IN_W-1:DROP_W];
  assign guard  = sig_in[DROP_W-1];
  assign sticky = |sig_in[DROP_W-2:0];
  assign inex_c = guard | sticky;

  always_comb begin
    case (mode)
      2'b00:   bump = guard & (sticky | kept[0]);
      2'b01:   bump = sign_in & inex_c;
      2'b10:   bump = ~sign_in & inex_c;
      default: bump = 1'b0;
    endcase
  end

  assign sum   = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};
  assign res_c = sum[KEEP_W] ? MSB_ONLY : sum[KEEP_W-1:0];

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sig_out   <= '0;
          carry_out <= 1'b0;
          inexact   <= 1'b0;
        end else begin
          sig_out   <= res_c;
          carry_out <= sum[KEEP_W];
          inexact   <= inex_c;
        end
      end
    end else begin : g_comb
      assign sig_out   = res_c;
      assign carry_out = sum[KEEP_W];
      assign inexact   = inex_c;
    end
  endgenerate
endmodule

// File: rtl/round4_unit_chk.sv
module round4_unit_chk #(
  parameter int IN_W    = 12,
  parameter int KEEP_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sign_in,
  input logic [IN_W-1:0]   sig_in,
  input logic [1:0]        mode,
  input logic [KEEP_W-1:0] sig_out,
  input logic              carry_out,
  input logic              inexact
);
  localparam int DROP_W = IN_W - KEEP_W;
  localparam logic [KEEP_W-1:0] MSB_ONLY = {1'b1, {(KEEP_W-1){1'b0}}};
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic              s_d;
  logic [IN_W-1:0]   m_d;
  logic [1:0]        r_d;
  logic [KEEP_W-1:0] kept_d;
  logic [DROP_W-1:0] drop_d;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_d <= 1'b0;
          m_d <= '0;
          r_d <= 2'b00;
        end else begin
          s_d <= sign_in;
          m_d <= sig_in;
          r_d <= mode;
        end
      end
    end else begin : g_now
      assign s_d = sign_in;
      assign m_d = sig_in;
      assign r_d = mode;
    end
  endgenerate

  assign kept_d = m_d[IN_W-1:DROP_W];
  assign drop_d = m_d[DROP_W-1:0];

  AST_NEVER_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_out |-> (sig_out == kept_d || sig_out == kept_d + KEEP_W'(1))); // R1
  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (r_d == 2'b00 && drop_d == HALF) |-> !sig_out[0]); // R2
  AST_NEG_INF_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (r_d == 2'b01 && !s_d) |-> (sig_out == kept_d && !carry_out)); // R3
  AST_POS_INF_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (r_d == 2'b10 && s_d) |-> (sig_out == kept_d && !carry_out)); // R4
  AST_TOWARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (r_d == 2'b11) |-> (sig_out == kept_d && !carry_out)); // R5
  AST_INEXACT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    inexact == (drop_d != '0)); // R6
  AST_CARRY_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (sig_out == MSB_ONLY && &kept_d)); // R7
  AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_d == '0) |-> (sig_out == kept_d && !carry_out)); // R8
endmodule

bind round4_unit round4_unit_chk #(.IN_W(IN_W), .KEEP_W(KEEP_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sign_in(sign_in), .sig_in(sig_in), .mode(mode),
  .sig_out(sig_out), .carry_out(carry_out), .inexact(inexact)
);

// File: tb/sim_round4_unit.sv
module sim_round4_unit;
  localparam int PERIOD = 10;
  localparam int IN_W   = 12;
  localparam int KEEP_W = 8;
  localparam int DROP_W = IN_W - KEEP_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sign_in = 1'b0;
  logic [IN_W-1:0]   sig_in = '0;
  logic [1:0]        mode = 2'b00;
  logic [KEEP_W-1:0] sig_out;
  logic              carry_out, inexact;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  round4_unit #(.IN_W(IN_W), .KEEP_W(KEEP_W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sign_in(sign_in), .sig_in(sig_in), .mode(mode),
    .sig_out(sig_out), .carry_out(carry_out), .inexact(inexact)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [KEEP_W+1:0] model(input logic s, input logic [IN_W-1:0] m,
                                              input logic [1:0] r);
    int unsigned k    = int'(m) / (1 << DROP_W);
    int unsigned rem  = int'(m) % (1 << DROP_W);
    int unsigned half = 1 << (DROP_W - 1);
    int unsigned k2, v;
    bit up, cy;
    case (r)
      2'b00:   up = (rem > half) || (rem == half && (k % 2) == 1);
      2'b01:   up = s && rem != 0;
      2'b10:   up = !s && rem != 0;
      default: up = 1'b0;
    endcase
    k2 = k + (up ? 1 : 0);
    cy = (k2 == (1 << KEEP_W));
    v  = cy ? (1 << (KEEP_W - 1)) : k2;
    return {cy, rem != 0, v[KEEP_W-1:0]};
  endfunction

  task automatic apply(input logic s, input logic [IN_W-1:0] m, input logic [1:0] r,
                       input string tag);
    logic [KEEP_W+1:0] exp_v, got;
    @(negedge clk);
    sign_in = s; sig_in = m; mode = r;
    @(negedge clk);
    exp_v = model(s, m, r);
    got   = {carry_out, inexact, sig_out};
    checks++;
    if (got !== exp_v) begin
      failures++;
      $display("FAIL %s s=%0b m=%h mode=%b actual=%h expected=%h", tag, s, m, r, got, exp_v);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    sign_in = 1'b1; sig_in = 12'hFFF; mode = 2'b10;
    repeat (3) @(negedge clk);
    checks++;
    if ({carry_out, inexact, sig_out} !== '0) begin
      failures++;
      $display("FAIL R9 reset actual=%h expected=0", {carry_out, inexact, sig_out});
    end
    rst_n = 1'b1;

    apply(1'b0, 12'hAB7, 2'b00, "R1");
    apply(1'b0, 12'hAB9, 2'b00, "R1");
    apply(1'b1, 12'hAB9, 2'b00, "R1");
    apply(1'b0, 12'hAA8, 2'b00, "R2");
    apply(1'b0, 12'hAB8, 2'b00, "R2");
    apply(1'b1, 12'hAB8, 2'b00, "R2");
    apply(1'b1, 12'hAB1, 2'b01, "R3");
    apply(1'b0, 12'hABF, 2'b01, "R3");
    apply(1'b0, 12'hAB1, 2'b10, "R4");
    apply(1'b1, 12'hABF, 2'b10, "R4");
    apply(1'b0, 12'hABF, 2'b11, "R5");
    apply(1'b1, 12'hFFF, 2'b11, "R5");
    apply(1'b0, 12'h001, 2'b11, "R6");
    apply(1'b1, 12'h008, 2'b01, "R6");
    apply(1'b0, 12'hFF8, 2'b00, "R7");
    apply(1'b0, 12'hFF1, 2'b10, "R7");
    apply(1'b1, 12'hFF1, 2'b01, "R7");
    apply(1'b1, 12'hFF1, 2'b10, "R7");
    for (int r = 0; r < 4; r++) begin
      apply(1'b0, 12'hAB0, 2'(r), "R8");
      apply(1'b1, 12'hFF0, 2'(r), "R8");
    end

    @(negedge clk);
    sign_in = 1'b0; sig_in = 12'h3C9; mode = 2'b00;
    @(posedge clk);
    #1;
    sig_in = 12'h000;
    @(negedge clk);
    checks++;
    if ({carry_out, inexact, sig_out} !== model(1'b0, 12'h3C9, 2'b00)) begin
      failures++;
      $display("FAIL R9 latency actual=%h expected=%h", {carry_out, inexact, sig_out},
               model(1'b0, 12'h3C9, 2'b00));
    end

    for (int i = 0; i < 400; i++) begin
      logic [IN_W-1:0] m = IN_W'($urandom);
      logic [1:0] r = 2'($urandom);
      logic s = 1'($urandom);
      if (i % 8 == 0) m[DROP_W-1:0] = {1'b1, {(DROP_W-1){1'b0}}};
      apply(s, m, r, (r == 2'b00) ? "R1" : (r == 2'b01) ? "R3" : (r == 2'b10) ? "R4" : "R5");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule